// File: doc/BRIEF.md
# G.711 Sample Compander

This block sits between a serial port's data registers and its shift logic. On the transmit side it takes a signed sample and packs it into an 8-bit code word. On the receive side it takes an 8-bit code word and unpacks it into a signed sample. Each direction has its own valid/ready handshake and its own mode input. The mode is sampled together with the word at the moment of transfer, so the mode can change from one word to the next.

There are four modes. Mu-law and A-law do logarithmic compression and expansion. Raw mode passes the 8-bit word through unchanged. Reversed mode passes it through with its bit order flipped, which serves links that send the least significant bit first. Code words are 8 bits in every mode, whatever word length the serial framing is set to. The two directions are independent, so either one can be fed from internal data while the serial sections are idle.

Top module: `g711_compander`

## Requirements
- R1: In mu-law mode (mode 2'b10) the 14 most significant sample bits are used as a signed value. Its magnitude is clamped to 8159 and then biased by 33. The segment is the position of the leading one minus 5, and the 4 bits below the leading one form the mantissa. The code is {positive ? 1 : 0, ~{seg[2:0], mant}}, so code bit 7 is 1 for a non-negative sample.
- R2: In A-law mode (mode 2'b11) the 13 most significant sample bits are used. A negative value is replaced by its ones' complement, which gives a 12-bit magnitude. Segment 0 covers magnitudes below 32 and uses magnitude bits [4:1] as the mantissa. Segment s ≥ 1 uses the 4 bits below the leading one. The code is {positive ? 1 : 0, {seg, mant} ^ 7'h55}.
- R3: Out-of-range inputs saturate. A full-scale positive sample gives 8'h80 in mu-law and 8'hAA in A-law. A full-scale negative sample gives 8'h00 in mu-law and 8'h2A in A-law.
- R4: Mu-law expansion works as follows. Let u = ~code and t = ({u[3:0],3'b0} + 132) << u[6:4]. The output is 132 − t when u[7] is 1 and t − 132 otherwise. The result is a 16-bit two's-complement value, left-justified in the sample.
- R5: A-law expansion works as follows. Let a = code ^ 8'h55. In segment 0, t = {a[3:0],4'b0} + 8. In segment s > 0, t = ({a[3:0],4'b0} + 264) << (s − 1). The output is t when a[7] is 1 and −t otherwise. The result is left-justified in 16 bits.
- R6: Mode 2'b00 passes the word straight through. Transmit sends the 8 low sample bits, and receive returns the code zero-extended. Mode 2'b01 does the same with the 8 bits reversed end for end.
- R7: A word accepted on a clock edge appears, registered, at the output on that same edge. The output valid drops after the word is taken if no new word is accepted.
- R8: While output valid is high and output ready is low, the output word stays stable and input ready stays low. Input ready is high whenever the output stage is empty or being drained.
- R9: Reset clears both output valids and leaves both input readies high.
- R10: The two directions run at the same time and do not affect each other. Each word uses the mode presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit sample offered |
| tx_in_ready | output | 1 | Transmit sample can be taken |
| tx_sample | input | SAMPLE_W | Transmit two's-complement sample |
| tx_mode | input | 2 | Transmit mode (00 raw, 01 reversed, 10 mu-law, 11 A-law) |
| tx_out_valid | output | 1 | Code word held for the shift register |
| tx_out_ready | input | 1 | Shift register takes the code word |
| tx_out_code | output | 8 | Compressed code word |
| rx_in_valid | input | 1 | Received code word offered |
| rx_in_ready | output | 1 | Code word can be taken |
| rx_code | input | 8 | Received code word |
| rx_mode | input | 2 | Receive mode (same encoding as tx_mode) |
| rx_out_valid | output | 1 | Expanded sample held |
| rx_out_ready | input | 1 | Receive register takes the sample |
| rx_sample | output | SAMPLE_W | Expanded sample |

## Verification
The hold and stall properties assume that upstream keeps a word and its mode steady until the handshake completes. The stimulus meets this by changing inputs only on the falling clock edge, after the previous word has been seen as accepted. The sign-bit and pass-through properties expect mode and data to be presented together in the accepting cycle. The random loop sets both directions in the same cycle, and the backpressure sequence holds the offered word while the output is stalled.

// File: rtl/g711_pkg.sv
package g711_pkg;
   localparam int CODE_W = 8;

   typedef enum logic [1:0] {
      CMODE_RAW = 2'b00,
      CMODE_REV = 2'b01,
      CMODE_MU  = 2'b10,
      CMODE_A   = 2'b11
   } cmode_t;

   function automatic logic [CODE_W-1:0] flip_bits(input logic [CODE_W-1:0] v);
      logic [CODE_W-1:0] r;
      for (int i = 0; i < CODE_W; i++) r[i] = v[CODE_W-1-i];
      return r;
   endfunction
endpackage

// File: rtl/g711_compress.sv
module g711_compress
   import g711_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [1:0]          mode,
   output logic [CODE_W-1:0]   code
);
   localparam int MU_W   = 14;
   localparam int AL_W   = 13;
   localparam int MU_CLIP = 8159;
   localparam int MU_BIAS = 33;

   logic [15:0] s16;
   assign s16 = sample[SAMPLE_W-1 -: 16];

   // mu-law path
   logic [MU_W-1:0] mu_x, mu_mag, mu_clip, mu_bias;
   logic            mu_neg;
   logic [3:0]      mu_msb;
   logic [3:0]      mu_seg;
   logic [3:0]      mu_mant;
   logic [6:0]      mu_low;
   logic [CODE_W-1:0] mu_code;

   assign mu_x    = s16[15 -: MU_W];
   assign mu_neg  = mu_x[MU_W-1];
   assign mu_mag  = mu_neg ? (~mu_x + 14'd1) : mu_x;
   assign mu_clip = (mu_mag > 14'(MU_CLIP)) ? 14'(MU_CLIP) : mu_mag;
   assign mu_bias = mu_clip + 14'(MU_BIAS);

   always_comb begin
      mu_msb = 4'd5;
      for (int i = 5; i < MU_W; i++) begin
         if (mu_bias[i]) mu_msb = 4'(i);
      end
   end

   assign mu_seg  = mu_msb - 4'd5;
   assign mu_mant = 4'(mu_bias >> (mu_msb - 4'd4));
   assign mu_low  = (mu_msb == 4'd13) ? 7'h7F : {mu_seg[2:0], mu_mant};
   assign mu_code = {~mu_neg, ~mu_low};

   // A-law path
   logic [AL_W-1:0] al_x;
   logic            al_neg;
   logic [11:0]     al_mag;
   logic [3:0]      al_msb;
   logic [2:0]      al_seg;
   logic [3:0]      al_sh;
   logic [3:0]      al_mant;
   logic [CODE_W-1:0] al_code;

   assign al_x   = s16[15 -: AL_W];
   assign al_neg = al_x[AL_W-1];
   assign al_mag = al_neg ? ~al_x[11:0] : al_x[11:0];

   always_comb begin
      al_msb = 4'd0;
      for (int i = 5; i < 12; i++) begin
         if (al_mag[i]) al_msb = 4'(i);
      end
   end

   assign al_seg  = (al_msb == 4'd0) ? 3'd0 : 3'(al_msb - 4'd4);
   assign al_sh   = (al_seg == 3'd0) ? 4'd1 : {1'b0, al_seg};
   assign al_mant = 4'(al_mag >> al_sh);
   assign al_code = {~al_neg, {al_seg, al_mant} ^ 7'h55};

   always_comb begin
      unique case (cmode_t'(mode))
         CMODE_RAW: code = sample[CODE_W-1:0];
         CMODE_REV: code = flip_bits(sample[CODE_W-1:0]);
         CMODE_MU:  code = mu_code;
         default:   code = al_code;
      endcase
   end
endmodule

// File: rtl/g711_expand.sv
module g711_expand
   import g711_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic [CODE_W-1:0]   code,
   input  logic [1:0]          mode,
   output logic [SAMPLE_W-1:0] sample
);
   localparam int LIN_W = 16;
   localparam int PAD_W = SAMPLE_W - LIN_W;

   // mu-law
   logic [CODE_W-1:0] u;
   logic [LIN_W-1:0]  mu_t, mu_lin;
   assign u      = ~code;
   assign mu_t   = (LIN_W'({u[3:0], 3'b000}) + 16'h0084) << u[6:4];
   assign mu_lin = u[7] ? (16'h0084 - mu_t) : (mu_t - 16'h0084);

   // A-law
   logic [CODE_W-1:0] a;
   logic [LIN_W-1:0]  al_base, al_t, al_lin;
   assign a       = code ^ 8'h55;
   assign al_base = LIN_W'({a[3:0], 4'b0000});
   assign al_t    = (a[6:4] == 3'd0) ? (al_base + 16'd8)
                                     : ((al_base + 16'h0108) << (a[6:4] - 3'd1));
   assign al_lin  = a[7] ? al_t : (16'd0 - al_t);

   logic [LIN_W-1:0]    lin;
   logic [SAMPLE_W-1:0] lin_just;
   assign lin = (mode == CMODE_MU) ? mu_lin : al_lin;

   generate
      if (PAD_W == 0) begin : g_exact
         assign lin_just = lin;
      end else begin : g_pad
         assign lin_just = {lin, {PAD_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (cmode_t'(mode))
         CMODE_RAW: sample = {{(SAMPLE_W-CODE_W){1'b0}}, code};
         CMODE_REV: sample = {{(SAMPLE_W-CODE_W){1'b0}}, flip_bits(code)};
         default:   sample = lin_just;
      endcase
   end
endmodule

// File: rtl/g711_hs_reg.sv
module g711_hs_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/g711_compander.sv
module g711_compander
   import g711_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_in_valid,
   output logic                tx_in_ready,
   input  logic [SAMPLE_W-1:0] tx_sample,
   input  logic [1:0]          tx_mode,
   output logic                tx_out_valid,
   input  logic                tx_out_ready,
   output logic [7:0]          tx_out_code,
   input  logic                rx_in_valid,
   output logic                rx_in_ready,
   input  logic [7:0]          rx_code,
   input  logic [1:0]          rx_mode,
   output logic                rx_out_valid,
   input  logic                rx_out_ready,
   output logic [SAMPLE_W-1:0] rx_sample
);
   generate
      if (SAMPLE_W < 16) begin : g_bad_width
         $error("SAMPLE_W must be at least 16");
      end
      if (CODE_W != 8) begin : g_bad_code
         $error("code words must be 8 bits");
      end
   endgenerate

   logic [CODE_W-1:0]   tx_code_c;
   logic [SAMPLE_W-1:0] rx_lin_c;

   g711_compress #(.SAMPLE_W(SAMPLE_W)) u_comp (
      .sample (tx_sample),
      .mode   (tx_mode),
      .code   (tx_code_c)
   );

   g711_hs_reg #(.W(CODE_W)) u_tx_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (tx_in_valid),
      .in_ready  (tx_in_ready),
      .in_data   (tx_code_c),
      .out_valid (tx_out_valid),
      .out_ready (tx_out_ready),
      .out_data  (tx_out_code)
   );

   g711_expand #(.SAMPLE_W(SAMPLE_W)) u_exp (
      .code   (rx_code),
      .mode   (rx_mode),
      .sample (rx_lin_c)
   );

   g711_hs_reg #(.W(SAMPLE_W)) u_rx_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_in_valid),
      .in_ready  (rx_in_ready),
      .in_data   (rx_lin_c),
      .out_valid (rx_out_valid),
      .out_ready (rx_out_ready),
      .out_data  (rx_sample)
   );
endmodule

// File: rtl/g711_compander_chk.sv
module g711_compander_chk
   import g711_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tx_in_valid,
   input logic                tx_in_ready,
   input logic [SAMPLE_W-1:0] tx_sample,
   input logic [1:0]          tx_mode,
   input logic                tx_out_valid,
   input logic                tx_out_ready,
   input logic [7:0]          tx_out_code,
   input logic                rx_in_valid,
   input logic                rx_in_ready,
   input logic [7:0]          rx_code,
   input logic [1:0]          rx_mode,
   input logic                rx_out_valid,
   input logic                rx_out_ready,
   input logic [SAMPLE_W-1:0] rx_sample
);
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_code)); // R8
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_sample)); // R8
   AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid && !tx_out_ready |-> !tx_in_ready); // R8
   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_in_valid && tx_in_ready |=> tx_out_valid); // R7
   AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid && rx_in_ready |=> rx_out_valid); // R7
   AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid && tx_out_ready && !tx_in_valid |=> !tx_out_valid); // R7
   AST_MU_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_in_valid && tx_in_ready && tx_mode == CMODE_MU && !tx_sample[SAMPLE_W-1]
      |=> tx_out_code[7]); // R1
   AST_A_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_in_valid && tx_in_ready && tx_mode == CMODE_A && !tx_sample[SAMPLE_W-1]
      |=> tx_out_code[7]); // R2
   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid && rx_in_ready && rx_mode == CMODE_RAW
      |=> rx_sample == {{(SAMPLE_W-8){1'b0}}, $past(rx_code)}); // R6
endmodule

bind g711_compander g711_compander_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_in_valid  (tx_in_valid),
   .tx_in_ready  (tx_in_ready),
   .tx_sample    (tx_sample),
   .tx_mode      (tx_mode),
   .tx_out_valid (tx_out_valid),
   .tx_out_ready (tx_out_ready),
   .tx_out_code  (tx_out_code),
   .rx_in_valid  (rx_in_valid),
   .rx_in_ready  (rx_in_ready),
   .rx_code      (rx_code),
   .rx_mode      (rx_mode),
   .rx_out_valid (rx_out_valid),
   .rx_out_ready (rx_out_ready),
   .rx_sample    (rx_sample)
);

// File: tb/g711_compander_bench.sv
module g711_compander_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_in_valid = 1'b0, tx_out_ready = 1'b1;
   logic        rx_in_valid = 1'b0, rx_out_ready = 1'b1;
   logic [15:0] tx_sample = '0;
   logic [1:0]  tx_mode = '0, rx_mode = '0;
   logic [7:0]  rx_code = '0;
   logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
   logic [7:0]  tx_out_code;
   logic [15:0] rx_sample;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   g711_compander u_g711_compander (
      .clk(clk), .rst_n(rst_n),
      .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_sample(tx_sample),
      .tx_mode(tx_mode), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
      .tx_out_code(tx_out_code),
      .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_code(rx_code),
      .rx_mode(rx_mode), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
      .rx_sample(rx_sample)
   );

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[7-i] = v[i];
      return r;
   endfunction

   function automatic logic [7:0] ref_comp(input logic [15:0] s, input logic [1:0] m);
      int pcm, mask, seg;
      if (m == 2'b00) return s[7:0];
      if (m == 2'b01) return rev8(s[7:0]);
      if (m == 2'b10) begin
         pcm = $signed(s) >>> 2;
         if (pcm < 0) begin pcm = -pcm; mask = 'h7F; end else mask = 'hFF;
         if (pcm > 8159) pcm = 8159;
         pcm = pcm + 33;
         seg = 8;
         for (int i = 7; i >= 0; i--) if (pcm <= (1 << (i + 6)) - 1) seg = i;
         if (seg >= 8) return 8'('h7F ^ mask);
         return 8'(((seg << 4) | ((pcm >> (seg + 1)) & 15)) ^ mask);
      end
      pcm = $signed(s) >>> 3;
      if (pcm >= 0) mask = 'hD5; else begin mask = 'h55; pcm = -pcm - 1; end
      seg = 8;
      for (int i = 7; i >= 0; i--) if (pcm <= (1 << (i + 5)) - 1) seg = i;
      if (seg >= 8) return 8'('h7F ^ mask);
      if (seg < 2) return 8'(((seg << 4) | ((pcm >> 1) & 15)) ^ mask);
      return 8'(((seg << 4) | ((pcm >> seg) & 15)) ^ mask);
   endfunction

   function automatic logic [15:0] ref_exp(input logic [7:0] c, input logic [1:0] m);
      int v, t, seg;
      if (m == 2'b00) return {8'h00, c};
      if (m == 2'b01) return {8'h00, rev8(c)};
      if (m == 2'b10) begin
         v = ~int'(c) & 255;
         t = ((v & 15) << 3) + 132;
         t = t << ((v & 'h70) >> 4);
         return 16'(((v & 128) != 0) ? (132 - t) : (t - 132));
      end
      v = int'(c) ^ 'h55;
      t = (v & 15) << 4;
      seg = (v & 'h70) >> 4;
      if (seg == 0) t = t + 8;
      else t = (t + 'h108) << (seg - 1);
      return 16'(((v & 128) != 0) ? t : -t);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // One word each way in the same cycle; result checked one edge later.
   task automatic xfer(input logic [15:0] ts, input logic [1:0] tm,
                       input logic [7:0] rc, input logic [1:0] rm, input string req);
      logic [7:0]  ec;
      logic [15:0] es;
      ec = ref_comp(ts, tm);
      es = ref_exp(rc, rm);
      @(negedge clk);
      tx_in_valid = 1'b1; tx_sample = ts; tx_mode = tm;
      rx_in_valid = 1'b1; rx_code = rc; rx_mode = rm;
      @(negedge clk);
      tx_in_valid = 1'b0; rx_in_valid = 1'b0;
      chk(tx_out_valid, {req, " R7 tx valid"}, 32'(tx_out_valid), 1);
      chk(tx_out_code == ec, {req, " R10 tx code"}, 32'(tx_out_code), 32'(ec));
      chk(rx_out_valid, {req, " R7 rx valid"}, 32'(rx_out_valid), 1);
      chk(rx_sample == es, {req, " R10 rx sample"}, 32'(rx_sample), 32'(es));
   endtask

   initial begin
      #(5.0 * 150000);
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] ra;
      void'($urandom(32'h5EED_0711));
      repeat (3) @(negedge clk);
      chk(!tx_out_valid && !rx_out_valid, "R9 valids in reset", {tx_out_valid, rx_out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_in_ready && rx_in_ready, "R9 ready after reset", {tx_in_ready, rx_in_ready}, 3);

      // R3 saturation corners
      xfer(16'h7FFF, 2'b10, 8'h00, 2'b10, "R3 mu +fs");
      chk(tx_out_code == 8'h80, "R3 mu +fs code", 32'(tx_out_code), 'h80);
      xfer(16'h8000, 2'b10, 8'hFF, 2'b10, "R3 mu -fs");
      chk(tx_out_code == 8'h00, "R3 mu -fs code", 32'(tx_out_code), 'h00);
      xfer(16'h7FFF, 2'b11, 8'h80, 2'b11, "R3 A +fs");
      chk(tx_out_code == 8'hAA, "R3 A +fs code", 32'(tx_out_code), 'hAA);
      xfer(16'h8000, 2'b11, 8'h7F, 2'b11, "R3 A -fs");
      chk(tx_out_code == 8'h2A, "R3 A -fs code", 32'(tx_out_code), 'h2A);
      // R1 and R2 boundaries: zero, -1, clip edge, segment edges
      xfer(16'h0000, 2'b10, 8'h55, 2'b01, "R1 zero");
      xfer(16'hFFFF, 2'b10, 8'hD5, 2'b00, "R1 minus one");
      xfer(16'(8159 * 4), 2'b10, 8'h7F, 2'b11, "R1 clip edge");
      xfer(16'(8160 * 4), 2'b10, 8'hAA, 2'b10, "R1 past clip");
      xfer(16'(31 * 8), 2'b11, 8'h01, 2'b11, "R2 seg0 top");
      xfer(16'(32 * 8), 2'b11, 8'hA5, 2'b11, "R2 seg1 start");
      xfer(16'hFF00, 2'b11, 8'h3C, 2'b01, "R2 negative");
      // R6 pass-through modes
      xfer(16'h12C3, 2'b00, 8'hC3, 2'b00, "R6 raw");
      chk(rx_sample == 16'h00C3, "R6 raw zero extend", 32'(rx_sample), 'hC3);
      xfer(16'h12C3, 2'b01, 8'h01, 2'b01, "R6 reversed");
      chk(tx_out_code == 8'hC3 && rx_sample == 16'h0080, "R6 reversed bits",
          {tx_out_code, rx_sample}, {8'hC3, 16'h0080});

      // R4 and R5: every code word in both laws
      for (int c = 0; c < 256; c++) begin
         xfer(16'(c * 129), 2'b10, 8'(c), 2'b10, "R4 mu sweep");
         xfer(16'(c * 131), 2'b11, 8'(c), 2'b11, "R5 A sweep");
      end

      // R8 backpressure: stall output, offer a second word
      @(negedge clk);
      tx_out_ready = 1'b0; rx_out_ready = 1'b0;
      tx_in_valid = 1'b1; tx_sample = 16'h1234; tx_mode = 2'b10;
      rx_in_valid = 1'b1; rx_code = 8'h9A; rx_mode = 2'b11;
      @(negedge clk);
      tx_sample = 16'hC000; tx_mode = 2'b11;
      rx_code = 8'h17; rx_mode = 2'b10;
      chk(!tx_in_ready && !rx_in_ready, "R8 ready low while stalled",
          {tx_in_ready, rx_in_ready}, 0);
      repeat (3) @(negedge clk);
      chk(tx_out_valid && tx_out_code == ref_comp(16'h1234, 2'b10), "R8 tx held",
          32'(tx_out_code), 32'(ref_comp(16'h1234, 2'b10)));
      chk(rx_out_valid && rx_sample == ref_exp(8'h9A, 2'b11), "R8 rx held",
          32'(rx_sample), 32'(ref_exp(8'h9A, 2'b11)));
      tx_out_ready = 1'b1; rx_out_ready = 1'b1;
      @(negedge clk);
      tx_in_valid = 1'b0; rx_in_valid = 1'b0;
      chk(tx_out_code == ref_comp(16'hC000, 2'b11), "R8 tx second word",
          32'(tx_out_code), 32'(ref_comp(16'hC000, 2'b11)));
      chk(rx_sample == ref_exp(8'h17, 2'b10), "R8 rx second word",
          32'(rx_sample), 32'(ref_exp(8'h17, 2'b10)));
      @(negedge clk);
      chk(!tx_out_valid && !rx_out_valid, "R7 drained", {tx_out_valid, rx_out_valid}, 0);

      // Random mix, modes changing per word (R1 R2 R4 R5 R6 R10)
      for (int n = 0; n < 1500; n++) begin
         ra = 16'($urandom);
         if (n % 7 == 0) ra = {ra[15], {15{~ra[15]}}} ^ 16'($urandom_range(0, 3));
         xfer(ra, 2'($urandom), 8'($urandom), 2'($urandom), "R10 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule